// File: doc/BRIEF.md
# Delayed Request-Pulse Handshake Responder

This block sits on one port of a unit that raises a per-port request and waits for a one-cycle answer pulse. The responder stays idle until it sees the request high. It then waits a programmed number of cycles and gives a single-cycle pulse. With a programmed delay of zero, the pulse appears combinationally in the same cycle that the request is first seen.

The responder works in one of two modes. As a supplier it feeds an operand: the programmed word appears on the data output only while the pulse is high, and the output is zero at all other times. As a sink it accepts a result: it compares the incoming word with a programmed expected value during the pulse cycle, and a mismatch raises a sticky error flag. A dedicated input clears that flag. A count of finished transactions lets a checker follow progress.

The delay, the data word and the mode are captured when the request is detected. Writing new settings while a transaction is counting therefore affects only later transactions.

Top module: `hs_responder`

## Requirements
- R1: After a synchronous active-high reset, `pulse_o` is 0, `put_data_o` is 0, `err_o` is 0 and `done_cnt_o` is 0, and the responder is idle.
- R2: While idle with `req_i` low, `pulse_o` stays 0 and `put_data_o` stays 0, whatever the settings are.
- R3: If `req_i` is first seen high while idle in cycle t and the captured delay D is nonzero, `pulse_o` is high in cycle t+D only, for exactly one cycle.
- R4: If the captured delay is zero, `pulse_o` is high combinationally in cycle t, the same cycle in which `req_i` is seen high while idle.
- R5: In supplier mode (`cfg_sink` = 0), `put_data_o` equals the captured data word in the pulse cycle and is zero in every other cycle.
- R6: In sink mode (`cfg_sink` = 1), `put_data_o` is always zero. `take_data_i` is compared with the captured expected word in the pulse cycle only. If they differ, `err_o` reads 1 from the next cycle; if they match, `err_o` is left unchanged.
- R7: `err_o` stays set until `clr_err_i` is high at a clock edge. If a mismatch and a clear fall in the same cycle, the mismatch wins and `err_o` stays 1.
- R8: `done_cnt_o` increases by exactly one in the cycle after each pulse, wraps modulo 2^CNT_W, and holds otherwise.
- R9: The delay, the data word and the mode are captured in the detection cycle. Changing `cfg_delay`, `cfg_data` or `cfg_sink` later in the same transaction changes neither its pulse timing, nor its data, nor its check.
- R10: Once counting has started, the transaction completes even if `req_i` falls. After the pulse the responder is idle again, and it starts a new transaction only when it sees `req_i` high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delay | input | DLY_W | Cycles from request detection to pulse |
| cfg_data | input | DATA_W | Word to supply (supplier) or expected word (sink) |
| cfg_sink | input | 1 | 0 = supplier mode, 1 = sink mode |
| req_i | input | 1 | Request from the served unit |
| pulse_o | output | 1 | One-cycle answer pulse |
| put_data_o | output | DATA_W | Supplied word, nonzero only in a supplier pulse cycle |
| take_data_i | input | DATA_W | Word offered by the served unit in sink mode |
| clr_err_i | input | 1 | Clears the sticky mismatch flag |
| err_o | output | 1 | Sticky mismatch flag |
| done_cnt_o | output | CNT_W | Count of finished transactions |

## Verification
A wrong count state shows on `pulse_o` within at most D cycles of detection: the pulse arrives early, late, twice, or not at all. A captured word or mode that is wrong, or not held, shows on `put_data_o` in the pulse cycle itself, or on `err_o` one cycle later. The bench changes the settings in the middle of transactions to expose these faults. A bad completion counter or a bad error latch shows on `done_cnt_o` and `err_o` in the cycle after the pulse, where every transaction is sampled.

// File: rtl/hs_resp_pkg.sv
package hs_resp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } hs_state_e;
endpackage

// File: rtl/hs_seq.sv
module hs_seq
  import hs_resp_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             launch_o,
  output logic             pulse_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  hs_state_e        st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             zero_dly;
  logic             wait_done;

  assign launch_o  = (st_q == ST_IDLE) && req_i;
  assign zero_dly  = (cfg_delay == '0);
  assign wait_done = (st_q == ST_WAIT) && (cnt_q == '0);
  assign pulse_o   = (launch_o && zero_dly) || wait_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (launch_o && !zero_dly) begin
            st_q  <= ST_WAIT;
            cnt_q <= cfg_delay - ONE;
          end
        end
        default: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - ONE;
        end
      endcase
    end
  end

  // R2: no pulse while idle and not requested
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !req_i) |-> !pulse_o);
  // R10: the pulse from the wait state leads back to idle
  p_back_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && pulse_o) |=> (st_q == ST_IDLE));
  // R3: counting moves strictly down while waiting
  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !pulse_o) |=> (st_q == ST_WAIT && cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/hs_dpath.sv
module hs_dpath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              pulse_i,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_sink,
  input  logic [DATA_W-1:0] take_data_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] put_data_o,
  output logic              err_o
);
  logic [DATA_W-1:0] word_q;
  logic              sink_q;
  logic [DATA_W-1:0] word_e;
  logic              sink_e;
  logic              miss;

  // the detection cycle uses live settings, later cycles the captured copy
  assign word_e = launch_i ? cfg_data : word_q;
  assign sink_e = launch_i ? cfg_sink : sink_q;

  assign put_data_o = (pulse_i && !sink_e) ? word_e : '0;
  assign miss       = pulse_i && sink_e && (take_data_i != word_e);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sink_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (launch_i) begin
        word_q <= cfg_data;
        sink_q <= cfg_sink;
      end
      if (miss)           err_o <= 1'b1;
      else if (clr_err_i) err_o <= 1'b0;
    end
  end

  // R5: data is zero outside the pulse
  p_put_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |-> (put_data_o == '0));
  // R6: sink mode never drives data
  p_sink_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (pulse_i && sink_e) |-> (put_data_o == '0));
  // R7: the flag holds without a clear
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_err_i) |=> err_o);
  // R9: the captured word holds while not launching
  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !launch_i |=> $stable(word_q));
endmodule

// File: rtl/hs_txn_cnt.sv
module hs_txn_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)          cnt_o <= '0;
    else if (pulse_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // R8: one step per pulse, hold otherwise
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |=> $stable(cnt_o));
endmodule

// File: rtl/hs_responder.sv
module hs_responder #(
  parameter int DLY_W  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_sink,
  input  logic              req_i,
  output logic              pulse_o,
  output logic [DATA_W-1:0] put_data_o,
  input  logic [DATA_W-1:0] take_data_i,
  input  logic              clr_err_i,
  output logic              err_o,
  output logic [CNT_W-1:0]  done_cnt_o
);
  logic launch;

  hs_seq #(.DLY_W(DLY_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .cfg_delay (cfg_delay),
    .launch_o  (launch),
    .pulse_o   (pulse_o)
  );

  hs_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .launch_i    (launch),
    .pulse_i     (pulse_o),
    .cfg_data    (cfg_data),
    .cfg_sink    (cfg_sink),
    .take_data_i (take_data_i),
    .clr_err_i   (clr_err_i),
    .put_data_o  (put_data_o),
    .err_o       (err_o)
  );

  hs_txn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (pulse_o),
    .cnt_o   (done_cnt_o)
  );

  // R4: a request seen in idle with zero delay pulses at once
  p_zero_now_r4: assert property (@(posedge clk) disable iff (rst)
    (launch && cfg_delay == '0) |-> pulse_o);
  // R3: a pulse never repeats in the next cycle without a new request
  p_single_r3: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && !req_i) |=> !pulse_o);
endmodule

// File: tb/tb_hs_responder.sv
module tb_hs_responder;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [DLY_W-1:0]  cfg_delay;
  logic [DATA_W-1:0] cfg_data;
  logic              cfg_sink;
  logic              req_i;
  logic              pulse_o;
  logic [DATA_W-1:0] put_data_o;
  logic [DATA_W-1:0] take_data_i;
  logic              clr_err_i;
  logic              err_o;
  logic [CNT_W-1:0]  done_cnt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit err_m = 1'b0;
  logic [CNT_W-1:0] cnt_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_responder #(.DLY_W(DLY_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .cfg_data(cfg_data),
    .cfg_sink(cfg_sink), .req_i(req_i), .pulse_o(pulse_o),
    .put_data_o(put_data_o), .take_data_i(take_data_i),
    .clr_err_i(clr_err_i), .err_o(err_o), .done_cnt_o(done_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_put(input bit go, input bit sink, input logic [DATA_W-1:0] d);
    return (go && !sink) ? d : '0;
  endfunction

  // one transaction seen from the served unit
  task automatic run_txn(input bit sink, input int dly, input logic [DATA_W-1:0] data,
                         input logic [DATA_W-1:0] dst, input bit perturb,
                         input bit drop_early, input bit clr_in_go);
    bit go_e;
    @(negedge clk);
    cfg_delay = DLY_W'(dly); cfg_data = data; cfg_sink = sink;
    take_data_i = dst; req_i = 1'b1;
    for (int k = 0; k <= dly; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1 && perturb) begin
        cfg_delay = DLY_W'(dly + 3); cfg_data = ~data; cfg_sink = ~sink;
      end
      if (k == 1 && drop_early) req_i = 1'b0;
      if (k == dly && clr_in_go) clr_err_i = 1'b1;
      #1;
      go_e = (k == dly);
      if (dly == 0) chk(pulse_o == go_e, "R4 pulse", pulse_o, go_e);
      else          chk(pulse_o == go_e, perturb ? "R9 pulse" : "R3 pulse", pulse_o, go_e);
      chk(put_data_o == exp_put(go_e, sink, data), sink ? "R6 put" : "R5 put",
          put_data_o, exp_put(go_e, sink, data));
    end
    if (sink && dst != data) err_m = 1'b1;
    else if (clr_in_go)      err_m = 1'b0;
    cnt_m = cnt_m + CNT_W'(1);
    @(negedge clk);
    req_i = 1'b0; clr_err_i = 1'b0;
    #1;
    chk(pulse_o == 1'b0, "R10 no repeat", pulse_o, 0);
    chk(put_data_o == '0, "R5 put after", put_data_o, 0);
    chk(err_o == err_m, clr_in_go ? "R7 err" : "R6 err", err_o, err_m);
    chk(done_cnt_o == cnt_m, "R8 count", done_cnt_o, cnt_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    rst = 1'b1; cfg_delay = '0; cfg_data = 16'h1234; cfg_sink = 1'b0;
    req_i = 1'b0; take_data_i = '0; clr_err_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(pulse_o == 0, "R1 pulse", pulse_o, 0);
    chk(put_data_o == 0, "R1 put", put_data_o, 0);
    chk(err_o == 0, "R1 err", err_o, 0);
    chk(done_cnt_o == 0, "R1 count", done_cnt_o, 0);

    // R2: idle with zero delay programmed and no request
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cfg_delay = '0; cfg_data = 16'hBEEF; #1;
      chk(pulse_o == 0, "R2 idle pulse", pulse_o, 0);
      chk(put_data_o == 0, "R2 idle put", put_data_o, 0);
    end

    // directed corners
    run_txn(0, 0, 16'h00AB, 16'h0, 0, 0, 0);      // R4 supplier, zero delay
    run_txn(1, 0, 16'h0055, 16'h0054, 0, 0, 0);   // R4/R6 sink mismatch
    run_txn(1, 2, 16'h0077, 16'h0077, 0, 0, 0);   // R6 match keeps flag set
    @(negedge clk); clr_err_i = 1'b1;             // R7 clear alone
    @(negedge clk); clr_err_i = 1'b0; err_m = 1'b0; #1;
    chk(err_o == 0, "R7 clear", err_o, 0);
    run_txn(1, 1, 16'h0010, 16'h0011, 0, 0, 1);   // R7 set wins over clear
    run_txn(0, 3, 16'hC0DE, 16'h0, 0, 0, 1);      // R7 clear in pulse cycle
    run_txn(0, 4, 16'hA5A5, 16'h0, 1, 0, 0);      // R9 reprogram while counting
    run_txn(1, 3, 16'h0F0F, 16'h0F0F, 1, 0, 0);   // R9 sink check uses captured word
    run_txn(0, 5, 16'h1357, 16'h0, 0, 1, 0);      // R10 request drops mid-wait
    run_txn(0, 255, 16'hFFFF, 16'h0, 0, 0, 0);    // R3 largest delay

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      bit s; int d; logic [DATA_W-1:0] w; logic [DATA_W-1:0] t;
      s = 1'($urandom_range(0, 1));
      d = $urandom_range(0, 6);
      w = DATA_W'($urandom);
      t = ($urandom_range(0, 3) == 0) ? (w ^ 16'h0100) : w;
      run_txn(s, d, w, t, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule